// File: doc/BRIEF.md
# PCI Target Read-Burst Data Output Stage

This block is the target-side output stage for PCI read bursts. Once a transaction starts, it pulls read words from an internal prefetch stream through a valid/ready handshake. It places the current word on the address/data output and drives TRDY#. A data phase completes on a clock where both TRDY# and IRDY# are sampled low. Only then does the output word register take the next word. On any other clock its clock enable stays off and the word on the bus is held.

TRDY# is computed only from the block's own state: whether a burst is active, whether a word sits in the output register, and whether that word was loaded on the previous clock. It never looks at the present level of IRDY#, so two agents using the same scheme cannot deadlock. A mode input selects between two behaviours:
- In full-speed mode, the next word is pulled in on the same edge that completes a phase, so one word can move on every clock.
- In the wait-first mode, TRDY# stays high on the first clock of every newly loaded word, which halves the peak rate.

When the initiator completes a phase with FRAME# high, the block releases TRDY# and the output enable on the next clock and returns to idle.

Top module: `pci_rdburst_out`

## Requirements
- R1: While reset is low and right after it, trdy_n and stop_n are 1, ad_oe is 0 and src_ready is 0.
- R2: While idle, sampling frame_n = 0 starts a burst, and ad_oe reads 1 from the next clock until the burst ends.
- R3: A data phase completes on a clock where trdy_n = 0 and irdy_n = 0. ad_out changes only when a word is loaded, and a word is loaded only into an empty output register or on a completing phase.
- R4: trdy_n is 0 exactly when a burst is active, the output register holds a word, and the wait-first rule does not apply. The present irdy_n never affects it, and trdy_n is 1 whenever ad_oe is 0.
- R5: src_ready is 1 only during a burst, and only when the output register is empty or a phase is completing with frame_n = 0. With irdy_n held at 0 and the source always valid in full-speed mode (slow_mode = 0), one word completes on every clock.
- R6: With slow_mode = 1, trdy_n is 1 on the first clock after each word is loaded. Consecutive completed phases are then at least two clocks apart.
- R7: When the source has no word after a phase completes, trdy_n goes to 1 and ad_out keeps the last word, unchanged, until a new word arrives.
- R8: A completing phase with frame_n = 1 ends the burst. On the next clock trdy_n = 1, ad_oe = 0 and src_ready = 0.
- R9: stop_n stays 1 at all times; the stage never requests a disconnect.
- R10: The initiator receives the source words in source order, with none skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | FRAME# from the initiator, active low |
| irdy_n | input | 1 | IRDY# from the initiator, active low |
| slow_mode | input | 1 | 1 = wait on the first clock of each word |
| src_data | input | DATA_W | Prefetch stream word |
| src_valid | input | 1 | Prefetch stream word is valid |
| src_ready | output | 1 | Stage takes the stream word on this clock |
| ad_out | output | DATA_W | Word presented on the address/data bus |
| ad_oe | output | 1 | Output enable for ad_out |
| trdy_n | output | 1 | TRDY#, active low |
| stop_n | output | 1 | STOP#, active low, held inactive |

## Verification
The embedded properties check several rules on every clock:
- the bus word holds through any clock without a completed phase;
- TRDY# stays off while the outputs are disabled;
- a fresh word waits one clock in the wait-first mode;
- a dry stream releases TRDY#;
- the end of a burst releases TRDY# and the enable.

Other behaviours only the bench scenarios can show, because they concern whole bursts rather than single clocks:
- the one-word-per-clock rate in full-speed mode and the two-clock spacing in the wait-first mode;
- delivery of every word in source order;
- a word held intact across a starved stretch.

// File: rtl/pci_rdb_pkg.sv
package pci_rdb_pkg;

  // A data phase completes when both ready strobes are low on the same edge.
  function automatic logic phase_done(input logic trdy_n, input logic irdy_n);
    return !trdy_n && !irdy_n;
  endfunction

  // TRDY# level from stage state only; the initiator's present IRDY# is never used.
  function automatic logic trdy_level(input logic active, input logic have,
                                      input logic fresh, input logic slow);
    return !(active && have && !(slow && fresh));
  endfunction

endpackage

// File: rtl/pci_rdb_phase_ctl.sv
module pci_rdb_phase_ctl
  import pci_rdb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic slow,
  input  logic have,
  input  logic fresh,
  output logic active,
  output logic trdy_n,
  output logic xfer,
  output logic last
);

  logic active_q;

  assign active = active_q;
  assign trdy_n = trdy_level(active_q, have, fresh, slow);
  assign xfer   = phase_done(trdy_n, irdy_n);
  assign last   = xfer && frame_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    active_q <= 1'b0;
    else if (!active_q && !frame_n) active_q <= 1'b1;
    else if (last)                 active_q <= 1'b0;
  end

  // R8
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (trdy_n && !active_q));

endmodule

// File: rtl/pci_rdb_word_reg.sv
module pci_rdb_word_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              xfer,
  input  logic              last,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic [DATA_W-1:0] data,
  output logic              have,
  output logic              fresh,
  output logic              load
);

  logic [DATA_W-1:0] data_q;
  logic              have_q;
  logic              fresh_q;

  // Clock enable of the word register: empty, or a completed phase (inverted IRDY# path).
  assign src_ready = active && (!have_q || (xfer && !last));
  assign load      = src_valid && src_ready;
  assign data      = data_q;
  assign have      = have_q;
  assign fresh     = fresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      have_q  <= 1'b0;
      fresh_q <= 1'b0;
    end else if (load) begin
      data_q  <= src_data;
      have_q  <= 1'b1;
      fresh_q <= 1'b1;
    end else begin
      fresh_q <= 1'b0;
      if (xfer) have_q <= 1'b0;
    end
  end

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && !xfer) |=> $stable(data_q));

endmodule

// File: rtl/pci_rdburst_out.sv
module pci_rdburst_out #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              slow_mode,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              trdy_n,
  output logic              stop_n
);

  logic active, xfer, last, have, fresh, load;

  pci_rdb_phase_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .slow    (slow_mode),
    .have    (have),
    .fresh   (fresh),
    .active  (active),
    .trdy_n  (trdy_n),
    .xfer    (xfer),
    .last    (last)
  );

  pci_rdb_word_reg #(.DATA_W(DATA_W)) u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .xfer      (xfer),
    .last      (last),
    .src_data  (src_data),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .data      (ad_out),
    .have      (have),
    .fresh     (fresh),
    .load      (load)
  );

  assign ad_oe  = active;
  assign stop_n = 1'b1;

  // R4
  idle_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |-> trdy_n);

  // R5
  ready_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> ad_oe);

  // R6
  slow_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode && load) |=> (trdy_n || !slow_mode));

  // R7
  dry_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !have && !load) |=> trdy_n);

endmodule

// File: tb/test_pci_rdburst_out.sv
module test_pci_rdburst_out;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_n = 1'b1;
  logic         irdy_n = 1'b1;
  logic         slow_mode = 1'b0;
  logic [W-1:0] src_data = '0;
  logic         src_valid = 1'b0;
  logic         src_ready;
  logic [W-1:0] ad_out;
  logic         ad_oe;
  logic         trdy_n;
  logic         stop_n;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;

  // behavioural reference state
  int m_act = 0, m_have = 0, m_fresh = 0;
  longint m_word = 0;
  int src_q[$];
  int exp_q[$];
  int rx_q[$];
  int first_x, last_x, dry_seen;
  int next_val = 32'h1000;

  always #5 clk = ~clk;

  pci_rdburst_out #(.DATA_W(W)) i_pci_rdburst_out (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .slow_mode(slow_mode), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .ad_out(ad_out), .ad_oe(ad_oe),
    .trdy_n(trdy_n), .stop_n(stop_n)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one clock: drive at negedge, compare against the model, advance the model at the edge
  task automatic step(input logic f, input logic ir, input logic sv);
    int e_trdy, done, e_rdy, took;
    @(negedge clk);
    frame_n   = f;
    irdy_n    = ir;
    src_valid = sv && (src_q.size() > 0);
    src_data  = (src_q.size() > 0) ? src_q[0] : 0;
    #1;
    e_trdy = (m_act != 0 && m_have != 0 && !(slow_mode && m_fresh != 0)) ? 0 : 1;
    done   = (e_trdy == 0 && ir == 1'b0) ? 1 : 0;
    e_rdy  = (m_act != 0 && (m_have == 0 || (done != 0 && f == 1'b0))) ? 1 : 0;
    chk(slow_mode ? "R6 trdy_n" : "R4 trdy_n", trdy_n, e_trdy);
    chk("R2/R8 ad_oe", ad_oe, m_act);
    chk("R5 src_ready", src_ready, e_rdy);
    chk("R3 ad_out", ad_out, m_word);
    chk("R9 stop_n", stop_n, 1);
    if (m_act != 0 && m_have == 0 && rx_q.size() > 0 && trdy_n === 1'b1 &&
        ad_out === W'(rx_q[rx_q.size()-1]))
      dry_seen++;
    took = (src_valid && e_rdy != 0) ? 1 : 0;
    if (done != 0) begin
      rx_q.push_back(int'(ad_out));
      if (first_x < 0) first_x = cyc;
      last_x = cyc;
    end
    @(posedge clk);
    cyc++;
    if (m_act == 0 && f == 1'b0) m_act = 1;
    else if (done != 0 && f == 1'b1) m_act = 0;
    if (took != 0) begin
      m_word = src_q.pop_front(); m_have = 1; m_fresh = 1;
    end else begin
      m_fresh = 0;
      if (done != 0) m_have = 0;
    end
  endtask

  // irdy_mode: 0 always ready, 1 wait every third clock; src_mode: 0 always, 1 every other, 2 every fourth
  task automatic run_burst(input int n, input int slow, input int irdy_mode, input int src_mode);
    int guard;
    logic ir, sv;
    slow_mode = slow[0];
    rx_q.delete(); exp_q.delete();
    first_x = -1; last_x = -1; dry_seen = 0;
    for (int k = 0; k < n; k++) begin
      src_q.push_back(next_val); exp_q.push_back(next_val); next_val += 7;
    end
    step(1'b0, 1'b1, 1'b0);
    guard = 0;
    while (rx_q.size() < n && guard < 2000) begin
      ir = (irdy_mode == 1 && (cyc % 3) == 0) ? 1'b1 : 1'b0;
      sv = (src_mode == 0) ? 1'b1 : (src_mode == 1) ? logic'((cyc % 2) == 0)
                                                    : logic'((cyc % 4) == 0);
      if (rx_q.size() == n - 1) step(1'b1, 1'b0, sv);
      else                      step(1'b0, ir, sv);
      guard++;
    end
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    // R10 order and count
    chk("R10 word count", rx_q.size(), n);
    for (int k = 0; k < n && k < rx_q.size(); k++)
      chk("R10 word order", rx_q[k], exp_q[k]);
    src_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    chk("R1 trdy_n in reset", trdy_n, 1);
    chk("R1 stop_n in reset", stop_n, 1);
    chk("R1 ad_oe in reset", ad_oe, 0);
    chk("R1 src_ready in reset", src_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1); // idle: irdy and stream must have no effect (R2)

    // R5 full speed, back-to-back: n words over n-1 clocks after the first
    run_burst(8, 0, 0, 0);
    chk("R5 full-speed spacing", last_x - first_x, 7);

    // R6 wait-first mode: two clocks per word
    run_burst(6, 1, 0, 0);
    chk("R6 slow spacing", last_x - first_x, 10);

    // R4 initiator waits; TRDY# held independent of IRDY#
    run_burst(10, 0, 1, 0);

    // R7 starved stream holds the word with TRDY# released
    run_burst(6, 0, 0, 2);
    chk("R7 held word while dry", (dry_seen > 0) ? 1 : 0, 1);

    // mixed: slow mode, waits, intermittent stream
    run_burst(7, 1, 1, 1);
    // single-word burst: address phase then final phase at once (R8)
    run_burst(1, 0, 0, 0);
    run_burst(5, 0, 1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule